// File: doc/BRIEF.md
# Serial Command Receiver with Mode Register

This block takes 8-bit commands from a host over a three-wire serial port made of an enable line, a shift clock and a data line. It then drives the mode controls of an optical disc front end from those commands: laser, focus servo, spindle speed mode, sled, tracking servo, and the two offset-trim enables. Bits are shifted in LSB first while enable is high. A frame is latched into a command register when enable falls. The command acts only on the next tick of a slow divided clock, so a host that sends frames back to back must hold enable low for longer than one tick period.

The focus-start and balance-start commands produce one-cycle pulses. The command register keeps its last complete byte. Any later enable falling edge that carries no complete byte therefore runs that byte again. Loading a harmless byte such as 0xFE stops this re-firing. Codes 0xF0 and 0xF8 arm a mask that drops the next executed byte, so the two-byte data that follows is not taken as a command. Code 0xFF disarms the mask without being dropped.

Top module: `serial_cmd_rx`

## Requirements
- R1: After rst_ni is released, every mode output is 0 (spindle_mode_o = 0 means off) and no start pulse has fired.
- R2: Bits are captured LSB first on rising shift clocks while enable is high. Nothing changes at the outputs while enable stays high, even after the eighth bit.
- R3: A command changes the outputs only in the cycle after an internal tick, which comes once every DIV core cycles. No output moves within two cycles of enable falling, and the change is complete within DIV+8 cycles.
- R4: 0x94 sets the laser and the focus servo on. 0x95 sets the laser off and the focus servo on. 0x96 sets both off.
- R5: 0x97, 0x98 and 0x99 set spindle_mode_o to 1 (8 cm), 2 (12 cm) and 0 (off). The value 3 never appears.
- R6: 0x9A turns the sled on and 0x9B turns it off. 0x9E turns the tracking servo on and 0x9D turns it off.
- R7: 0x90 and 0x91 set and clear the focus offset-adjust output. 0x92 and 0x93 set and clear the track offset-adjust output.
- R8: 0x08 gives exactly one cycle of focus_start_o. 0x9C gives exactly one cycle of bal_start_o.
- R9: An enable window with fewer than 8 shift clocks runs the stored command again, so a start pulse fires again. After 0xFE is loaded, such a window gives no pulse.
- R10: After 0xF0 or 0xF8 is executed, the next executed byte is dropped, unless it is 0xFF. 0xFF only disarms the mask.
- R11: Command 0x00 and rst_ni both return all mode outputs to 0.
- R12: Unlisted codes leave every output unchanged. A window with fewer than 8 clocks discards its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sen_i | input | 1 | Serial enable, frame active while high |
| sclk_i | input | 1 | Serial shift clock |
| sdat_i | input | 1 | Serial data, LSB first |
| laser_on_o | output | 1 | Laser on |
| focus_servo_o | output | 1 | Focus servo enabled |
| spindle_mode_o | output | 2 | 0 off, 1 8 cm, 2 12 cm |
| sled_on_o | output | 1 | Sled enabled |
| track_servo_o | output | 1 | Tracking servo enabled |
| focus_ofs_adj_o | output | 1 | Focus offset trim active |
| track_ofs_adj_o | output | 1 | Track offset trim active |
| focus_start_o | output | 1 | One-cycle focus search start |
| bal_start_o | output | 1 | One-cycle balance start |

## Verification
The bench builds the block with DIV = 8. This keeps the wait for the execution tick short, so a few dozen frames fit easily, while still leaving a gap between the enable fall and the output change that can be observed. With that short window the bench can check that nothing moves two cycles after enable falls and that the new mode is settled DIV+8 cycles later. It can also drive many short re-trigger windows, mask sequences and reset cases, each compared against a per-frame behavioural model.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;
  localparam int unsigned CMD_W = 8;

  typedef enum logic [1:0] {
    SPIN_OFF = 2'd0,
    SPIN_8   = 2'd1,
    SPIN_12  = 2'd2
  } spin_e;

  typedef struct packed {
    logic  laser;
    logic  focus;
    spin_e spin;
    logic  sled;
    logic  track;
    logic  fofs;
    logic  tofs;
  } mode_t;

  localparam mode_t MODE_INIT = '{laser: 1'b0, focus: 1'b0, spin: SPIN_OFF,
                                  sled: 1'b0, track: 1'b0, fofs: 1'b0, tofs: 1'b0};

  localparam logic [CMD_W-1:0] C_RESET  = 8'h00;
  localparam logic [CMD_W-1:0] C_FSTART = 8'h08;
  localparam logic [CMD_W-1:0] C_FOFS_S = 8'h90;
  localparam logic [CMD_W-1:0] C_FOFS_X = 8'h91;
  localparam logic [CMD_W-1:0] C_TOFS_S = 8'h92;
  localparam logic [CMD_W-1:0] C_TOFS_X = 8'h93;
  localparam logic [CMD_W-1:0] C_LAS_ON = 8'h94;
  localparam logic [CMD_W-1:0] C_FS_ON  = 8'h95;
  localparam logic [CMD_W-1:0] C_FS_OFF = 8'h96;
  localparam logic [CMD_W-1:0] C_SP8    = 8'h97;
  localparam logic [CMD_W-1:0] C_SP12   = 8'h98;
  localparam logic [CMD_W-1:0] C_SPOFF  = 8'h99;
  localparam logic [CMD_W-1:0] C_SLD_ON = 8'h9A;
  localparam logic [CMD_W-1:0] C_SLD_OF = 8'h9B;
  localparam logic [CMD_W-1:0] C_BAL    = 8'h9C;
  localparam logic [CMD_W-1:0] C_TRK_OF = 8'h9D;
  localparam logic [CMD_W-1:0] C_TRK_ON = 8'h9E;
  localparam logic [CMD_W-1:0] C_ARM_A  = 8'hF0;
  localparam logic [CMD_W-1:0] C_ARM_B  = 8'hF8;
  localparam logic [CMD_W-1:0] C_DISARM = 8'hFF;
endpackage

// File: rtl/serial_cmd_sync.sv
module serial_cmd_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/serial_cmd_shift.sv
module serial_cmd_shift
  import serial_cmd_pkg::*;
#(
  parameter int unsigned CW = CMD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sen_i,
  input  logic          sclk_i,
  input  logic          sdat_i,
  output logic          fall_o,
  output logic [CW-1:0] cmd_o
);
  localparam int unsigned CNT_W = $clog2(CW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CW);

  logic            sen_d_q, sclk_d_q;
  logic [CW-1:0]   sr_q, cmd_q;
  logic [CNT_W-1:0] cnt_q;
  logic            sclk_rise;

  assign sclk_rise = sclk_i & ~sclk_d_q;
  assign fall_o    = sen_d_q & ~sen_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sen_d_q  <= 1'b0;
      sclk_d_q <= 1'b0;
      sr_q     <= '0;
      cnt_q    <= '0;
      cmd_q    <= '0;
    end else begin
      sen_d_q  <= sen_i;
      sclk_d_q <= sclk_i;
      if (!sen_i) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        sr_q <= {sdat_i, sr_q[CW-1:1]};
        if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
      end
      // short frames keep the previous byte, which then re-executes
      if (fall_o && cnt_q == CNT_FULL) cmd_q <= sr_q;
    end
  end

  assign cmd_o = cmd_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  // R12
  short_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o && cnt_q != CNT_FULL) |=> $stable(cmd_q));
endmodule

// File: rtl/serial_cmd_tick.sv
module serial_cmd_tick #(
  parameter int unsigned DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  output logic exec_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;
  logic          pend_q, tick;

  assign tick   = (div_q == LAST);
  assign exec_o = tick & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      div_q  <= tick ? '0 : div_q + 1'b1;
      pend_q <= fall_i | (pend_q & ~tick);
    end
  end

  // R3
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !tick) |=> pend_q);
endmodule

// File: rtl/serial_cmd_decode.sv
module serial_cmd_decode
  import serial_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_i,
  input  logic [CMD_W-1:0] cmd_i,
  output mode_t            mode_o,
  output logic             fstart_o,
  output logic             bal_o
);
  mode_t mode_q;
  logic  arm_q, fstart_q, bal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_INIT;
      arm_q    <= 1'b0;
      fstart_q <= 1'b0;
      bal_q    <= 1'b0;
    end else begin
      fstart_q <= 1'b0;
      bal_q    <= 1'b0;
      if (exec_i) begin
        if (arm_q) begin
          arm_q <= 1'b0;  // masked byte, or 0xFF disarm
        end else begin
          unique case (cmd_i)
            C_RESET:  mode_q <= MODE_INIT;
            C_FSTART: fstart_q <= 1'b1;
            C_BAL:    bal_q <= 1'b1;
            C_FOFS_S: mode_q.fofs <= 1'b1;
            C_FOFS_X: mode_q.fofs <= 1'b0;
            C_TOFS_S: mode_q.tofs <= 1'b1;
            C_TOFS_X: mode_q.tofs <= 1'b0;
            C_LAS_ON: begin mode_q.laser <= 1'b1; mode_q.focus <= 1'b1; end
            C_FS_ON:  begin mode_q.laser <= 1'b0; mode_q.focus <= 1'b1; end
            C_FS_OFF: begin mode_q.laser <= 1'b0; mode_q.focus <= 1'b0; end
            C_SP8:    mode_q.spin <= SPIN_8;
            C_SP12:   mode_q.spin <= SPIN_12;
            C_SPOFF:  mode_q.spin <= SPIN_OFF;
            C_SLD_ON: mode_q.sled <= 1'b1;
            C_SLD_OF: mode_q.sled <= 1'b0;
            C_TRK_ON: mode_q.track <= 1'b1;
            C_TRK_OF: mode_q.track <= 1'b0;
            C_ARM_A, C_ARM_B: arm_q <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  assign mode_o   = mode_q;
  assign fstart_o = fstart_q;
  assign bal_o    = bal_q;

  // R3
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(mode_q));
  // R8
  fs_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fstart_q |=> !fstart_q);
  // R8
  bal_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bal_q |=> !bal_q);
  // R8
  start_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fstart_q || bal_q) |-> $past(exec_i));
  // R10
  mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && arm_q) |=> ($stable(mode_q) && !fstart_q && !bal_q && !arm_q));
  // R5
  spin_enc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.spin != 2'b11);
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_cmd_pkg::*;
#(
  parameter int unsigned DIV = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sen_i,
  input  logic       sclk_i,
  input  logic       sdat_i,
  output logic       laser_on_o,
  output logic       focus_servo_o,
  output logic [1:0] spindle_mode_o,
  output logic       sled_on_o,
  output logic       track_servo_o,
  output logic       focus_ofs_adj_o,
  output logic       track_ofs_adj_o,
  output logic       focus_start_o,
  output logic       bal_start_o
);
  logic [2:0]       pins_s;
  logic             fall, exec;
  logic [CMD_W-1:0] cmd;
  mode_t            mode;

  serial_cmd_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdat_i, sclk_i, sen_i}),
    .q_o   (pins_s)
  );

  serial_cmd_shift #(.CW(CMD_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sen_i (pins_s[0]),
    .sclk_i(pins_s[1]),
    .sdat_i(pins_s[2]),
    .fall_o(fall),
    .cmd_o (cmd)
  );

  serial_cmd_tick #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fall_i(fall),
    .exec_o(exec)
  );

  serial_cmd_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .exec_i  (exec),
    .cmd_i   (cmd),
    .mode_o  (mode),
    .fstart_o(focus_start_o),
    .bal_o   (bal_start_o)
  );

  assign laser_on_o      = mode.laser;
  assign focus_servo_o   = mode.focus;
  assign spindle_mode_o  = mode.spin;
  assign sled_on_o       = mode.sled;
  assign track_servo_o   = mode.track;
  assign focus_ofs_adj_o = mode.fofs;
  assign track_ofs_adj_o = mode.tofs;
endmodule

// File: tb/serial_cmd_rx_bench.sv
module serial_cmd_rx_bench;
  localparam int DIV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sen = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic laser, focus, sled, track, fofs, tofs, fst, bal;
  logic [1:0] spin;

  always #5 clk = ~clk;

  serial_cmd_rx #(.DIV(DIV)) u_serial_cmd_rx (
    .clk_i(clk), .rst_ni(rst_n), .sen_i(sen), .sclk_i(sclk), .sdat_i(sdat),
    .laser_on_o(laser), .focus_servo_o(focus), .spindle_mode_o(spin),
    .sled_on_o(sled), .track_servo_o(track), .focus_ofs_adj_o(fofs),
    .track_ofs_adj_o(tofs), .focus_start_o(fst), .bal_start_o(bal)
  );

  int checks = 0, errors = 0;
  int fs_seen = 0, bal_seen = 0, fs_exp = 0, bal_exp = 0;

  // behavioural model
  logic [7:0] m_vec = 8'h00;  // {laser,focus,spin[1:0],sled,track,fofs,tofs}
  logic [7:0] m_cmd = 8'h00;
  bit         m_arm = 0;

  always @(posedge clk) begin
    if (fst) fs_seen++;
    if (bal) bal_seen++;
  end

  function automatic logic [7:0] outs();
    return {laser, focus, spin, sled, track, fofs, tofs};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_exec();
    if (m_arm) begin
      m_arm = 0;
    end else begin
      case (m_cmd)
        8'h00: m_vec = 8'h00;
        8'h08: fs_exp++;
        8'h9C: bal_exp++;
        8'h90: m_vec[1] = 1'b1;
        8'h91: m_vec[1] = 1'b0;
        8'h92: m_vec[0] = 1'b1;
        8'h93: m_vec[0] = 1'b0;
        8'h94: m_vec[7:6] = 2'b11;
        8'h95: m_vec[7:6] = 2'b01;
        8'h96: m_vec[7:6] = 2'b00;
        8'h97: m_vec[5:4] = 2'd1;
        8'h98: m_vec[5:4] = 2'd2;
        8'h99: m_vec[5:4] = 2'd0;
        8'h9A: m_vec[3] = 1'b1;
        8'h9B: m_vec[3] = 1'b0;
        8'h9E: m_vec[2] = 1'b1;
        8'h9D: m_vec[2] = 1'b0;
        8'hF0, 8'hF8: m_arm = 1;
        default: ;
      endcase
    end
  endtask

  task automatic send(input logic [7:0] b, input int nbits, input string tag);
    sen = 1'b1;
    wcyc(4);
    for (int i = 0; i < nbits; i++) begin
      sdat = b[i];
      wcyc(4);
      sclk = 1'b1;
      wcyc(4);
      sclk = 1'b0;
    end
    wcyc(4);
    chk("R2 held while enable high", outs(), m_vec);
    sen = 1'b0;
    wcyc(2);
    chk("R3 no change right after fall", outs(), m_vec);
    if (nbits >= 8) m_cmd = b;
    model_exec();
    wcyc(DIV + 8);
    chk(tag, outs(), m_vec);
    chk({tag, " focus pulses"}, fs_seen, fs_exp);
    chk({tag, " balance pulses"}, bal_seen, bal_exp);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wcyc(3);
    rst_n = 1'b1;
    wcyc(2);
    chk("R1 reset outputs", outs(), 8'h00);
    chk("R1 no pulses", fs_seen + bal_seen, 0);

    send(8'h94, 8, "R4 laser on");
    send(8'h95, 8, "R4 laser off focus on");
    send(8'h96, 8, "R4 both off");
    send(8'h97, 8, "R5 spindle 8");
    send(8'h98, 8, "R5 spindle 12");
    send(8'h99, 8, "R5 spindle off");
    send(8'h9A, 8, "R6 sled on");
    send(8'h9E, 8, "R6 track on");
    send(8'h90, 8, "R7 focus ofs on");
    send(8'h92, 8, "R7 track ofs on");
    send(8'h91, 8, "R7 focus ofs off");
    send(8'h93, 8, "R7 track ofs off");
    send(8'h9B, 8, "R6 sled off");
    send(8'h9D, 8, "R6 track off");

    send(8'h08, 8, "R8 focus start");
    send(8'h00, 3, "R9 refire focus start");
    send(8'hFE, 8, "R9 clear");
    send(8'h08, 2, "R9 no refire after clear");
    send(8'h9C, 8, "R8 balance start");
    send(8'h00, 5, "R9 refire balance");
    send(8'hFE, 8, "R9 clear balance");

    send(8'h94, 8, "R12 setup");
    send(8'h96, 5, "R12 short frame discarded");
    send(8'h55, 8, "R12 unlisted code");

    send(8'hF0, 8, "R10 arm A");
    send(8'h9A, 8, "R10 masked byte");
    send(8'h9A, 8, "R10 after mask");
    send(8'hF8, 8, "R10 arm B");
    send(8'hFF, 8, "R10 disarm");
    send(8'h9B, 8, "R10 executes after disarm");

    send(8'h98, 8, "R11 setup");
    send(8'h00, 8, "R11 reset command");
    chk("R11 reset command all off", outs(), 8'h00);

    send(8'h94, 8, "R11 setup hw");
    rst_n = 1'b0;
    wcyc(2);
    chk("R11 rst_ni clears", outs(), 8'h00);
    rst_n = 1'b1;
    m_vec = 8'h00; m_cmd = 8'h00; m_arm = 0;
    wcyc(2);
    send(8'h97, 8, "R3 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule